// File: doc/BRIEF.md
# Five-Channel Buffered Down-Counter Timer

This peripheral holds five independent down-counters that share one register bus and one tick-enable input. Software never writes a live counter directly. It fills a per-channel count buffer and then pulses that channel's manual-update bit, which copies the buffer into the counter. When a count runs out, the channel pulses its own interrupt line. The counter then either refills from the buffer (periodic operation) or parks at zero (single-shot operation).

All channel controls sit in one shared control word. Each channel's live count can be read back through an observation word. Loading the all-ones value with reload enabled gives a free-running counter. Its bitwise complement rises steadily and can serve as a timestamp.

The register bus is plain and synchronous: address, write data and write strobe, with registered read data. It has no handshake, because every access completes in one cycle.

Top module: `tmr_bank`

## Requirements
- R1: After reset every counter, buffer and the control word are zero, all `irq` bits are low and `bus_rdata` is zero.
- R2: The control word is at 0x08. Channel n (n = 0 to 3) uses bit b+0 for start, b+1 for manual update and b+3 for reload, with b = 0, 8, 12 and 16. Channel 4 uses bit 20 for start, bit 21 for manual update and bit 22 for reload. Every other bit is discarded on write and reads as zero, so writing all ones reads back 0x007BBB0B.
- R3: While a channel's manual-update bit is set, its counter is loaded from its count buffer on every cycle. It does not decrement and raises no interrupt.
- R4: A counter decrements by one only on a cycle where `tick_en` is high, its start bit is set and its manual-update bit is clear. With start clear or `tick_en` low, the counter holds its value.
- R5: A tick that arrives with the counter at zero is an expiry. The channel's `irq` bit is high for exactly the following cycle. With buffer value N-1 and `tick_en` held high, expiries come N cycles apart.
- R6: With reload set, an expiry reloads the counter from the count buffer's value at that moment. A buffer write made while the channel is running therefore takes effect at the next expiry.
- R7: With reload clear, the first expiry leaves the counter at zero, and no further interrupt is raised until a manual update rearms the channel.
- R8: For n = 0 to 3, the count buffer is at 0x0C+12n, the compare buffer at 0x10+12n and the observation word at 0x14+12n. Channel 4 has a count buffer at 0x3C, an observation word at 0x40 and no compare buffer. Buffers read back what was written. Any address not listed reads as zero.
- R9: `bus_rdata` is registered. It shows the value held at the address presented one clock earlier, taken before any write on that same edge.
- R10: The channels are independent. `irq[n]` belongs to channel n only, and activity on one channel never moves another channel's counter.
- R11: A channel loaded with the all-ones value and running with reload set counts such that the complement of its observation word strictly increases across ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 32 | Registered read data |
| tick_en | input | 1 | Shared count enable for all channels |
| irq | output | 5 | Per-channel expiry pulse, bit n for channel n |

## Verification
The bench builds the block with its default 32-bit counter width and 8-bit address. This allows the all-ones load and the complement-increasing check on channel 4 to run on the real field width. Small buffer values such as 1, 2 and 4 bring several periodic expiries, a one-shot park and a rearm within a few dozen cycles. Gating `tick_en` and clearing start while other channels run puts the hold rules and channel independence under the same per-clock comparison.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int NCH  = 5;
  localparam int LAST = NCH - 1;
  localparam int CTRL_OFS = 'h08;

  typedef struct packed {
    logic start;
    logic manual;
    logic reload;
  } chan_ctl_t;

  // Field base of each channel inside the shared control word
  function automatic int fld_base(int n);
    return (n == 0) ? 0 : 4 + 4 * n;
  endfunction

  function automatic int start_bit(int n);
    return fld_base(n);
  endfunction

  function automatic int manual_bit(int n);
    return fld_base(n) + 1;
  endfunction

  function automatic int reload_bit(int n);
    return (n == LAST) ? fld_base(n) + 2 : fld_base(n) + 3;
  endfunction

  function automatic logic [31:0] ctrl_mask();
    logic [31:0] m;
    m = '0;
    for (int n = 0; n < NCH; n++) begin
      m[start_bit(n)]  = 1'b1;
      m[manual_bit(n)] = 1'b1;
      m[reload_bit(n)] = 1'b1;
    end
    return m;
  endfunction

  function automatic int cbuf_ofs(int n);
    return (n == LAST) ? 'h3C : 'h0C + 12 * n;
  endfunction

  function automatic int cmp_ofs(int n);
    return 'h10 + 12 * n;
  endfunction

  function automatic int obs_ofs(int n);
    return (n == LAST) ? 'h40 : 'h14 + 12 * n;
  endfunction
endpackage

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  chan_ctl_t        ctl,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt,
  output logic             irq
);
  logic done_q;
  logic run;
  logic at_zero;

  assign run     = ctl.start && !ctl.manual && tick && !done_q;
  assign at_zero = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      done_q <= 1'b0;
      irq    <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (ctl.manual) begin
        cnt    <= load_val;
        done_q <= 1'b0;
      end else if (run) begin
        if (at_zero) begin
          irq <= 1'b1;
          if (ctl.reload) cnt <= load_val;
          else            done_q <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  // R3: manual update copies the buffer and suppresses expiry
  a_r3_manual_load: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.manual |=> (cnt == $past(load_val)) && !irq);

  // R4: no start and no manual update means the count holds
  a_r4_hold_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.start && !ctl.manual) |=> $stable(cnt));

  // R4: an enabled tick above zero steps down by one
  a_r4_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !at_zero) |=> cnt == $past(cnt) - 1'b1);

  // R5: a pulse only follows an enabled tick at zero
  a_r5_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(ctl.start && !ctl.manual && tick && at_zero));

  // R6: periodic expiry refills from the buffer
  a_r6_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (run && at_zero && ctl.reload) |=> cnt == $past(load_val));

  // R7: single-shot expiry parks at zero
  a_r7_park: assert property (@(posedge clk) disable iff (!rst_n)
    (run && at_zero && !ctl.reload) |=> at_zero);
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_we,
  output logic [31:0]       bus_rdata,
  output chan_ctl_t         ctl      [NCH],
  output logic [CNT_W-1:0]  load_val [NCH],
  input  logic [CNT_W-1:0]  live_cnt [NCH]
);
  localparam logic [31:0] MASK = ctrl_mask();

  logic [31:0]      ctrl_q;
  logic [CNT_W-1:0] cbuf_q [NCH];
  logic [CNT_W-1:0] cmp_q  [LAST];
  logic [31:0]      rd_next;

  function automatic logic [31:0] widen(logic [CNT_W-1:0] v);
    logic [31:0] w;
    w = '0;
    w[CNT_W-1:0] = v;
    return w;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else if (bus_we && bus_addr == ADDR_W'(CTRL_OFS)) ctrl_q <= bus_wdata & MASK;
  end

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cbuf_q[n] <= '0;
      else if (bus_we && bus_addr == ADDR_W'(cbuf_ofs(n))) cbuf_q[n] <= bus_wdata[CNT_W-1:0];
    end

    if (n < LAST) begin : g_cmp
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cmp_q[n] <= '0;
        else if (bus_we && bus_addr == ADDR_W'(cmp_ofs(n))) cmp_q[n] <= bus_wdata[CNT_W-1:0];
      end
    end

    assign ctl[n].start  = ctrl_q[start_bit(n)];
    assign ctl[n].manual = ctrl_q[manual_bit(n)];
    assign ctl[n].reload = ctrl_q[reload_bit(n)];
    assign load_val[n]   = cbuf_q[n];
  end

  always_comb begin
    rd_next = '0;
    if (bus_addr == ADDR_W'(CTRL_OFS)) rd_next = ctrl_q;
    for (int n = 0; n < NCH; n++) begin
      if (bus_addr == ADDR_W'(cbuf_ofs(n))) rd_next = widen(cbuf_q[n]);
      if (bus_addr == ADDR_W'(obs_ofs(n)))  rd_next = widen(live_cnt[n]);
    end
    for (int n = 0; n < LAST; n++) begin
      if (bus_addr == ADDR_W'(cmp_ofs(n))) rd_next = widen(cmp_q[n]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= '0;
    else        bus_rdata <= rd_next;
  end

  // R2: the control word never holds a bit outside the field map
  a_r2_ctrl_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q & ~MASK) == '0);
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_we,
  output logic [31:0]       bus_rdata,
  input  logic              tick_en,
  output logic [NCH-1:0]    irq
);
  chan_ctl_t        ctl      [NCH];
  logic [CNT_W-1:0] load_val [NCH];
  logic [CNT_W-1:0] live_cnt [NCH];

  tmr_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .bus_rdata (bus_rdata),
    .ctl       (ctl),
    .load_val  (load_val),
    .live_cnt  (live_cnt)
  );

  for (genvar n = 0; n < NCH; n++) begin : g_chan
    tmr_chan #(.CNT_W(CNT_W)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick_en),
      .ctl      (ctl[n]),
      .load_val (load_val[n]),
      .cnt      (live_cnt[n]),
      .irq      (irq[n])
    );
  end
endmodule

// File: tb/tmr_bank_test.sv
`timescale 1ns/1ps
module tmr_bank_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_rdata;
  logic        tick_en = 1'b0;
  logic [4:0]  irq;

  int total = 0;
  int bad = 0;
  bit live = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  tmr_bank uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .tick_en(tick_en), .irq(irq)
  );

  // Behavioural reference model
  int unsigned SB[5] = '{0, 8, 12, 16, 20};
  int unsigned RB[5] = '{3, 11, 15, 19, 22};
  int unsigned m_ctrl;
  int unsigned m_cbuf[5];
  int unsigned m_cmp[4];
  int unsigned m_cnt[5];
  bit          m_done[5];
  bit [4:0]    m_irq;
  int unsigned m_rd;

  function automatic int unsigned m_mask();
    int unsigned m = 0;
    for (int n = 0; n < 5; n++) m |= (1 << SB[n]) | (1 << (SB[n] + 1)) | (1 << RB[n]);
    return m;
  endfunction

  function automatic int unsigned m_read(int unsigned a);
    if (a == 8) return m_ctrl;
    for (int n = 0; n < 4; n++) begin
      if (a == 12 + 12 * n) return m_cbuf[n];
      if (a == 16 + 12 * n) return m_cmp[n];
      if (a == 20 + 12 * n) return m_cnt[n];
    end
    if (a == 'h3C) return m_cbuf[4];
    if (a == 'h40) return m_cnt[4];
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 0; m_irq = '0; m_rd = 0;
      for (int n = 0; n < 5; n++) begin m_cbuf[n] = 0; m_cnt[n] = 0; m_done[n] = 0; end
      for (int n = 0; n < 4; n++) m_cmp[n] = 0;
    end else begin
      m_rd = m_read(bus_addr);
      for (int n = 0; n < 5; n++) begin
        bit st, mu, rl;
        st = m_ctrl[SB[n]]; mu = m_ctrl[SB[n] + 1]; rl = m_ctrl[RB[n]];
        m_irq[n] = 0;
        if (mu) begin
          m_cnt[n] = m_cbuf[n]; m_done[n] = 0;
        end else if (st && tick_en && !m_done[n]) begin
          if (m_cnt[n] == 0) begin
            m_irq[n] = 1;
            if (rl) m_cnt[n] = m_cbuf[n];
            else    m_done[n] = 1;
          end else m_cnt[n] = m_cnt[n] - 1;
        end
      end
      if (bus_we) begin
        if (bus_addr == 8) m_ctrl = bus_wdata & m_mask();
        for (int n = 0; n < 4; n++) begin
          if (bus_addr == 12 + 12 * n) m_cbuf[n] = bus_wdata;
          if (bus_addr == 16 + 12 * n) m_cmp[n] = bus_wdata;
        end
        if (bus_addr == 'h3C) m_cbuf[4] = bus_wdata;
      end
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Per-clock comparison of every output against the model
  always @(negedge clk) begin
    if (live) begin
      chk({cur_req, " irq"}, {27'd0, irq}, {27'd0, m_irq});
      chk({cur_req, " rdata"}, bus_rdata, m_rd);
    end
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] v);
    @(negedge clk); bus_addr = a;
    @(negedge clk); v = bus_rdata;
  endtask

  task automatic idle(int c);
    repeat (c) @(negedge clk);
  endtask

  // Cycles from one irq[ch] pulse to the next
  task automatic gap(int ch, output int g);
    g = 0;
    while (irq[ch] !== 1'b1) @(negedge clk);
    @(negedge clk); g = 1;
    while (irq[ch] !== 1'b1 && g < 100) begin @(negedge clk); g++; end
  endtask

  task automatic pulses(int ch, int c, output int p);
    p = 0;
    for (int i = 0; i < c; i++) begin @(negedge clk); if (irq[ch] === 1'b1) p++; end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #600000;
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] v, v2;
    int g, p;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    live = 1;

    // R1: reset state
    cur_req = "R1";
    chk("R1 irq", {27'd0, irq}, 32'd0);
    rd(8'h08, v);  chk("R1 ctrl", v, 0);
    rd(8'h0C, v);  chk("R1 cbuf0", v, 0);
    rd(8'h40, v);  chk("R1 obs4", v, 0);

    // R8: map and read-back
    cur_req = "R8";
    wr(8'h0C, 32'd5); wr(8'h10, 32'h77); wr(8'h3C, 32'd9); wr(8'h34, 32'hA5A5);
    rd(8'h0C, v); chk("R8 cbuf0", v, 5);
    rd(8'h10, v); chk("R8 cmp0", v, 32'h77);
    rd(8'h34, v); chk("R8 cmp3", v, 32'hA5A5);
    rd(8'h3C, v); chk("R8 cbuf4", v, 9);
    rd(8'h00, v); chk("R8 unmapped 00", v, 0);
    rd(8'h44, v); chk("R8 unmapped 44", v, 0);
    rd(8'h04, v); chk("R8 unmapped 04", v, 0);

    // R2: field mask
    cur_req = "R2";
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h08, v); chk("R2 mask", v, 32'h007B_BB0B);
    wr(8'h08, 32'h0);

    // R9: registered read, old value on the write edge
    cur_req = "R9";
    @(negedge clk); bus_addr = 8'h08; bus_wdata = 32'h0000_0800; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0; chk("R9 old", bus_rdata, 0);
    @(negedge clk); chk("R9 new", bus_rdata, 32'h0000_0800);
    wr(8'h08, 32'h0);

    // R3: manual update holds the buffer value
    cur_req = "R3";
    wr(8'h0C, 32'd4); wr(8'h08, 32'h2);
    idle(2);
    rd(8'h14, v); chk("R3 loaded", v, 4);
    tick_en = 1'b1;
    idle(4);
    rd(8'h14, v); chk("R3 no step", v, 4);

    // R5: period of buffer+1 ticks
    cur_req = "R5";
    wr(8'h08, 32'h9);
    gap(0, g); chk("R5 gap", g, 5);

    // R6: buffer rewrite applies at next expiry
    cur_req = "R6";
    wr(8'h0C, 32'd1);
    gap(0, g); gap(0, g); chk("R6 new gap", g, 2);

    // R4: gated ticks and stop-freeze
    cur_req = "R4";
    for (int i = 0; i < 16; i++) begin @(negedge clk); tick_en = i[0]; end
    tick_en = 1'b0;
    rd(8'h14, v); idle(5); rd(8'h14, v2); chk("R4 tick low hold", v2, v);
    wr(8'h08, 32'h8);
    tick_en = 1'b1;
    rd(8'h14, v); idle(5); rd(8'h14, v2); chk("R4 stopped hold", v2, v);

    // R7: single shot then rearm
    cur_req = "R7";
    wr(8'h24, 32'd2); wr(8'h08, 32'h2000); wr(8'h08, 32'h1000);
    pulses(2, 20, p); chk("R7 one pulse", p, 1);
    rd(8'h2C, v); chk("R7 parked", v, 0);
    wr(8'h08, 32'h2000); wr(8'h08, 32'h1000);
    pulses(2, 20, p); chk("R7 rearm", p, 1);

    // R10: two channels at once, others silent
    cur_req = "R10";
    wr(8'h18, 32'd2); wr(8'h30, 32'd5);
    wr(8'h08, 32'h0002_0200); wr(8'h08, 32'h0009_0900);
    pulses(0, 30, p); chk("R10 ch0 quiet", p, 0);
    gap(1, g); chk("R10 ch1 gap", g, 3);
    gap(3, g); chk("R10 ch3 gap", g, 6);
    rd(8'h2C, v); chk("R10 ch2 untouched", v, 0);

    // R11: free-running all-ones channel
    cur_req = "R11";
    wr(8'h3C, 32'hFFFF_FFFF);
    wr(8'h08, 32'h0020_0000); wr(8'h08, 32'h0050_0000);
    rd(8'h40, v); idle(3); rd(8'h40, v2);
    chk("R11 rising complement", {31'd0, (~v2) > (~v)}, 32'd1);

    live = 0;
    idle(2);
    finish_run();
  end
endmodule